// File: doc/BRIEF.md
# Decimating Symmetric FIR Filter

This block is a programmable FIR post-filter for a stream of 18-bit frequency samples. Each sample enters with a one-cycle valid strobe and is written into a circular sample history. After every N accepted samples, N being the programmed decimation factor, the block computes one filtered output. The computation uses a single multiply-accumulate unit that is time-shared over several clock cycles. A larger decimation factor therefore leaves room for longer filters.

Coefficients are loaded through a plain write port with address, data and write enable. In symmetric mode only the first half of the impulse response is stored. Each pair of mirrored samples is summed (mirror symmetry) or differenced (anti-mirror symmetry) before it is multiplied, so a filter of up to 63 taps needs at most 32 multiplies. In asymmetric mode up to 32 independent coefficients are applied one per sample. The sum is rounded, scaled by a programmable right shift and saturated to a 16-bit two's-complement word. A sticky flag reports a decimation boundary that arrived while the previous computation was still running.

Top module: `decim_sym_fir`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, overrun is 0, and the sample history and all coefficients are zero.
- R2: Only cycles with in_valid high count as samples. One result is started on every cfg_decim-th accepted sample (cfg_decim of 0 acts as 1). Each result appears as a single-cycle out_valid pulse, and out_data changes only with out_valid.
- R3: Symmetric mode (cfg_symmetric=1, cfg_anti=0) with T taps, where x[0] is the sample that completed the decimation period and x[j] is the sample j accepted inputs earlier: the sum is the sum over k < (T+1)/2 of coef[k] * (x[k] + x[T-1-k]).
- R4: With cfg_anti=1 in symmetric mode, each pair term is coef[k] * (x[k] - x[T-1-k]).
- R5: With an odd T in symmetric mode, the centre term k=(T-1)/2 uses its sample once: coef[k]*x[k] under mirror symmetry, and zero under anti-mirror symmetry.
- R6: Asymmetric mode (cfg_symmetric=0): the sum is the sum over k < T of coef[k]*x[k], with T clamped to 32. A cfg_taps value of 0 acts as 1 in both modes.
- R7: out_data = saturate16((sum + 2^(s-1)) >> s), using an arithmetic shift, where s = cfg_shift and no rounding term is added for s=0. The saturation limits are -32768 and 32767.
- R8: A decimation boundary that occurs while a result is still being computed produces no result and sets overrun. Overrun stays 1 until reset.
- R9: Coefficient addresses at or above the number of multiplies in use (T in asymmetric mode, (T+1)/2 in symmetric mode) have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 18 | Input sample, two's complement |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 5 | Coefficient index |
| coef_wdata | input | 16 | Coefficient value, two's complement |
| cfg_taps | input | 6 | Tap count T (1 to 63) |
| cfg_symmetric | input | 1 | 1 selects symmetric pre-addition |
| cfg_anti | input | 1 | 1 selects anti-mirror (subtracting) symmetry |
| cfg_decim | input | 8 | Decimation factor N |
| cfg_shift | input | 5 | Output right shift s |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Filtered result, two's complement |
| overrun | output | 1 | Sticky missed-boundary flag |

## Verification
A corrupted history pointer or pair index shows up on the very next out_valid as a result that differs from the bench's sum. A wrong pre-add sign or a wrong centre-tap rule does the same, and the odd tap counts and anti-mirror rows expose these errors within one decimation period. A decimation counter that skips or double-counts shifts the out_valid pulse, or makes it disappear, within N accepted samples. A busy state that is not tracked correctly is seen either as a missing overrun after back-to-back boundaries on a 63-tap filter or as a spurious overrun in the gapped tests.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam int DATA_W   = 18;
    localparam int COEF_W   = 16;
    localparam int OUT_W    = 16;
    localparam int MAX_TAPS = 63;
    localparam int MAX_ASYM = 32;
    localparam int DEC_W    = 8;
    localparam int SHIFT_W  = 5;

    localparam int TAP_W   = $clog2(MAX_TAPS + 1);
    localparam int COEF_N  = MAX_ASYM;
    localparam int COEF_AW = $clog2(COEF_N);
    localparam int HIST_AW = $clog2(MAX_TAPS) + 1;
    localparam int HIST_N  = 1 << HIST_AW;
    localparam int PRE_W   = DATA_W + 1;
    localparam int PROD_W  = PRE_W + COEF_W;
    localparam int ACC_W   = PROD_W + COEF_AW;

    typedef struct packed {
        logic [TAP_W-1:0]   taps;
        logic               symmetric;
        logic               anti;
        logic [SHIFT_W-1:0] shift;
    } fir_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_MAC  = 2'd1,
        ENG_OUT  = 2'd2
    } eng_state_e;

    function automatic logic [TAP_W-1:0] eff_taps(input fir_cfg_t c);
        logic [TAP_W-1:0] t;
        t = (c.taps == '0) ? TAP_W'(1) : c.taps;
        if (!c.symmetric && (t > TAP_W'(MAX_ASYM))) t = TAP_W'(MAX_ASYM);
        return t;
    endfunction

    function automatic logic [TAP_W-1:0] last_mac(input fir_cfg_t c);
        logic [TAP_W-1:0] t;
        t = eff_taps(c) - TAP_W'(1);
        return c.symmetric ? (t >> 1) : t;
    endfunction

    function automatic logic signed [OUT_W-1:0] round_sat(
        input logic signed [ACC_W-1:0] a,
        input logic [SHIFT_W-1:0]      s
    );
        logic signed [ACC_W:0] r;
        logic signed [ACC_W:0] half;
        logic signed [ACC_W:0] hi;
        logic signed [ACC_W:0] lo;
        r    = {a[ACC_W-1], a};
        half = '0;
        if (s != '0) half = signed'((ACC_W+1)'(1) << (s - SHIFT_W'(1)));
        r    = (r + half) >>> s;
        hi   = signed'((ACC_W+1)'((1 << (OUT_W - 1)) - 1));
        lo   = -hi - signed'((ACC_W+1)'(1));
        if (r > hi)      return hi[OUT_W-1:0];
        else if (r < lo) return lo[OUT_W-1:0];
        else             return r[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/sdf_hist.sv
module sdf_hist
    import sdf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = HIST_AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_data,
    output logic [AW-1:0]        wr_ptr,
    input  logic [AW-1:0]        rd_a_idx,
    input  logic [AW-1:0]        rd_b_idx,
    output logic signed [DW-1:0] rd_a,
    output logic signed [DW-1:0] rd_b
);
    localparam int DEPTH = 1 << AW;

    logic signed [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            wr_ptr      <= wr_ptr + AW'(1);
        end
    end

    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];
endmodule

// File: rtl/sdf_coef.sv
module sdf_coef
    import sdf_pkg::*;
#(
    parameter int CW = COEF_W,
    parameter int AW = COEF_AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [CW-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic signed [CW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic signed [CW-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
        end else if (we) begin
            bank[waddr] <= wdata;
        end
    end

    assign rdata = bank[raddr];
endmodule

// File: rtl/sdf_mac.sv
module sdf_mac
    import sdf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [HIST_AW-1:0]       base,
    input  fir_cfg_t                 cfg,
    output logic [HIST_AW-1:0]       rd_a_idx,
    output logic [HIST_AW-1:0]       rd_b_idx,
    input  logic signed [DATA_W-1:0] rd_a,
    input  logic signed [DATA_W-1:0] rd_b,
    output logic [COEF_AW-1:0]       coef_idx,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     busy,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    eng_state_e                st;
    fir_cfg_t                  cfg_q;
    logic [HIST_AW-1:0]        base_q;
    logic [TAP_W-1:0]          k;
    logic signed [ACC_W-1:0]   acc;

    logic [TAP_W-1:0]          t_eff;
    logic [TAP_W-1:0]          k_last;
    logic [TAP_W-1:0]          mirror;
    logic signed [PRE_W-1:0]   a_ext;
    logic signed [PRE_W-1:0]   b_ext;
    logic signed [PRE_W-1:0]   pre;
    logic signed [PROD_W-1:0]  prod;

    always_comb begin
        t_eff    = eff_taps(cfg_q);
        k_last   = last_mac(cfg_q);
        mirror   = t_eff - TAP_W'(1) - k;
        rd_a_idx = base_q - HIST_AW'(k);
        rd_b_idx = base_q - HIST_AW'(mirror);
        coef_idx = k[COEF_AW-1:0];
        a_ext    = signed'({rd_a[DATA_W-1], rd_a});
        b_ext    = signed'({rd_b[DATA_W-1], rd_b});
        if (!cfg_q.symmetric) begin
            pre = a_ext;
        end else if (mirror == k) begin
            pre = cfg_q.anti ? '0 : a_ext;
        end else begin
            pre = cfg_q.anti ? (a_ext - b_ext) : (a_ext + b_ext);
        end
        prod = pre * coef;
    end

    assign busy = (st != ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ENG_IDLE;
            cfg_q     <= '0;
            base_q    <= '0;
            k         <= '0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (st)
                ENG_IDLE: begin
                    if (start) begin
                        cfg_q  <= cfg;
                        base_q <= base;
                        k      <= '0;
                        acc    <= '0;
                        st     <= ENG_MAC;
                    end
                end
                ENG_MAC: begin
                    acc <= acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
                    if (k == k_last) st <= ENG_OUT;
                    else             k  <= k + TAP_W'(1);
                end
                ENG_OUT: begin
                    out_data  <= round_sat(acc, cfg_q.shift);
                    out_valid <= 1'b1;
                    st        <= ENG_IDLE;
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/decim_sym_fir.sv
module decim_sym_fir
    import sdf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               coef_we,
    input  logic [COEF_AW-1:0] coef_addr,
    input  logic [COEF_W-1:0]  coef_wdata,
    input  logic [TAP_W-1:0]   cfg_taps,
    input  logic               cfg_symmetric,
    input  logic               cfg_anti,
    input  logic [DEC_W-1:0]   cfg_decim,
    input  logic [SHIFT_W-1:0] cfg_shift,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic               overrun
);
    logic [DEC_W-1:0]          dcnt;
    logic [DEC_W-1:0]          dec_last;
    logic                      boundary;
    logic                      start;
    logic                      busy;
    fir_cfg_t                  cfg;
    logic [HIST_AW-1:0]        wr_ptr;
    logic [HIST_AW-1:0]        rd_a_idx;
    logic [HIST_AW-1:0]        rd_b_idx;
    logic signed [DATA_W-1:0]  rd_a;
    logic signed [DATA_W-1:0]  rd_b;
    logic [COEF_AW-1:0]        coef_idx;
    logic signed [COEF_W-1:0]  coef;
    logic signed [OUT_W-1:0]   result;

    always_comb begin
        cfg.taps      = cfg_taps;
        cfg.symmetric = cfg_symmetric;
        cfg.anti      = cfg_anti;
        cfg.shift     = cfg_shift;
        dec_last      = (cfg_decim == '0) ? '0 : (cfg_decim - DEC_W'(1));
        boundary      = in_valid && (dcnt >= dec_last);
        start         = boundary && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt    <= '0;
            overrun <= 1'b0;
        end else if (in_valid) begin
            dcnt <= boundary ? '0 : (dcnt + DEC_W'(1));
            if (boundary && busy) overrun <= 1'b1;
        end
    end

    sdf_hist #(.DW(DATA_W), .AW(HIST_AW)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (in_valid),
        .wr_data  (signed'(in_data)),
        .wr_ptr   (wr_ptr),
        .rd_a_idx (rd_a_idx),
        .rd_b_idx (rd_b_idx),
        .rd_a     (rd_a),
        .rd_b     (rd_b)
    );

    sdf_coef #(.CW(COEF_W), .AW(COEF_AW)) u_coef (
        .clk   (clk),
        .rst   (rst),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (signed'(coef_wdata)),
        .raddr (coef_idx),
        .rdata (coef)
    );

    sdf_mac u_mac (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base      (wr_ptr),
        .cfg       (cfg),
        .rd_a_idx  (rd_a_idx),
        .rd_b_idx  (rd_b_idx),
        .rd_a      (rd_a),
        .rd_b      (rd_b),
        .coef_idx  (coef_idx),
        .coef      (coef),
        .busy      (busy),
        .out_valid (out_valid),
        .out_data  (result)
    );

    assign out_data = result;
endmodule

// File: rtl/decim_sym_fir_chk.sv
module decim_sym_fir_chk
    import sdf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             overrun
);
    // R1: outputs are quiet on the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !overrun));

    // R2: a result strobe lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2: the result word moves only together with its strobe
    a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_data) |-> out_valid);

    // R8: the missed-boundary flag never clears outside reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R8: the flag rises only after an accepted sample
    a_r8_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(in_valid));
endmodule

bind decim_sym_fir decim_sym_fir_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overrun   (overrun)
);

// File: tb/test_decim_sym_fir.sv
module test_decim_sym_fir;

    typedef struct packed {
        logic [5:0] taps;
        logic       sym;
        logic       anti;
        logic [7:0] dec;
        logic [4:0] sh;
        logic [7:0] seed;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{6'd7,  1'b1, 1'b0, 8'd1, 5'd4, 8'd1},
        '{6'd8,  1'b1, 1'b0, 8'd2, 5'd3, 8'd2},
        '{6'd8,  1'b1, 1'b1, 8'd3, 5'd2, 8'd3},
        '{6'd9,  1'b1, 1'b1, 8'd1, 5'd0, 8'd4},
        '{6'd63, 1'b1, 1'b0, 8'd4, 5'd6, 8'd5},
        '{6'd12, 1'b0, 1'b0, 8'd2, 5'd5, 8'd6},
        '{6'd40, 1'b0, 1'b0, 8'd1, 5'd6, 8'd7},
        '{6'd1,  1'b0, 1'b0, 8'd5, 5'd0, 8'd8},
        '{6'd63, 1'b1, 1'b1, 8'd2, 5'd7, 8'd9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [17:0] in_data = '0;
    logic        coef_we = 1'b0;
    logic [4:0]  coef_addr = '0;
    logic [15:0] coef_wdata = '0;
    logic [5:0]  cfg_taps = 6'd1;
    logic        cfg_symmetric = 1'b0;
    logic        cfg_anti = 1'b0;
    logic [7:0]  cfg_decim = 8'd1;
    logic [4:0]  cfg_shift = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        overrun;

    always #5 clk = ~clk;

    decim_sym_fir i_decim_sym_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .cfg_taps(cfg_taps), .cfg_symmetric(cfg_symmetric), .cfg_anti(cfg_anti),
        .cfg_decim(cfg_decim), .cfg_shift(cfg_shift),
        .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );

    int     nchk = 0;
    int     nerr = 0;
    int     nout = 0;
    longint last_out = 0;
    bit     reported = 1'b0;
    longint hist [4096];
    int     hcnt = 0;
    longint cf [32];
    int     sidx = 0;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            nout++;
            last_out = longint'($signed(out_data));
        end
    end

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint xs(input int j);
        return (hcnt - 1 - j >= 0) ? hist[hcnt - 1 - j] : 0;
    endfunction

    function automatic longint model();
        int     t;
        int     s;
        longint acc;
        longint pre;
        t   = (cfg_taps == 0) ? 1 : int'(cfg_taps);
        s   = int'(cfg_shift);
        acc = 0;
        if (cfg_symmetric) begin
            for (int k = 0; k < (t + 1) / 2; k++) begin
                int j = t - 1 - k;
                if (j == k) pre = cfg_anti ? 0 : xs(k);
                else        pre = cfg_anti ? (xs(k) - xs(j)) : (xs(k) + xs(j));
                acc += pre * cf[k];
            end
        end else begin
            if (t > 32) t = 32;
            for (int k = 0; k < t; k++) acc += xs(k) * cf[k];
        end
        if (s > 0) acc += longint'(1) << (s - 1);
        acc = acc >>> s;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        coef_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hcnt = 0;
        for (int k = 0; k < 32; k++) cf[k] = 0;
    endtask

    task automatic write_coef(input int k, input longint v);
        @(negedge clk);
        coef_we = 1'b1;
        coef_addr = k[4:0];
        coef_wdata = v[15:0];
        cf[k] = v;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic load_coefs(input int seed);
        for (int k = 0; k < 32; k++) write_coef(k, longint'(((k * 37 + seed * 11) % 201) - 100));
    endtask

    task automatic feed(input longint s);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = s[17:0];
        hist[hcnt] = s;
        hcnt++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_out(input int n0, output bit got);
        got = 1'b0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (nout > n0) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic next_sample(output longint s);
        s = longint'(((sidx * 7919 + 131) % 4001) - 2000);
        sidx++;
    endtask

    initial begin
        bit     got;
        longint exp;
        longint s;
        int     n0;

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1 out_valid after reset", longint'(out_valid), 0);
        chk("R1 out_data after reset", longint'($signed(out_data)), 0);
        chk("R1 overrun after reset", longint'(overrun), 0);

        // Vector table: R3 R4 R5 R6 across tap counts, symmetries and decimation
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            int    nb;
            do_reset();
            cfg_taps = VECS[v].taps;
            cfg_symmetric = VECS[v].sym;
            cfg_anti = VECS[v].anti;
            cfg_decim = VECS[v].dec;
            cfg_shift = VECS[v].sh;
            load_coefs(int'(VECS[v].seed));
            if (!VECS[v].sym)      tag = "R6 asymmetric sum";
            else if (VECS[v].anti) tag = VECS[v].taps[0] ? "R4 R5 anti-mirror odd taps" : "R4 anti-mirror";
            else                   tag = VECS[v].taps[0] ? "R3 R5 mirror odd taps" : "R3 mirror";
            nb = 64 / int'(VECS[v].dec) + 3;
            for (int b = 0; b < nb; b++) begin
                n0 = nout;
                for (int i = 0; i < int'(VECS[v].dec); i++) begin
                    next_sample(s);
                    feed(s);
                end
                exp = model();
                wait_out(n0, got);
                chk({tag, " strobe"}, longint'(got), 1);
                chk(tag, last_out, exp);
            end
            chk("R8 no overrun when paced", longint'(overrun), 0);
        end

        // R2: gapped samples and decimation count
        do_reset();
        cfg_taps = 6'd3; cfg_symmetric = 1'b0; cfg_anti = 1'b0;
        cfg_decim = 8'd3; cfg_shift = 5'd0;
        load_coefs(12);
        n0 = nout;
        feed(100);
        repeat (5) @(negedge clk);
        feed(-250);
        repeat (40) @(negedge clk);
        chk("R2 no result before N samples", longint'(nout - n0), 0);
        feed(77);
        exp = model();
        wait_out(n0, got);
        chk("R2 result on Nth sample", longint'(got), 1);
        chk("R2 result value", last_out, exp);
        @(negedge clk);
        chk("R2 single-cycle strobe", longint'(out_valid), 0);

        // R2: decimation factor 0 acts as 1
        cfg_decim = 8'd0;
        n0 = nout;
        feed(-31);
        exp = model();
        wait_out(n0, got);
        chk("R2 decim zero acts as one", longint'(got), 1);
        chk("R2 decim zero value", last_out, exp);

        // R7: rounding and saturation with one tap
        do_reset();
        cfg_taps = 6'd1; cfg_symmetric = 1'b0; cfg_decim = 8'd1; cfg_shift = 5'd0;
        write_coef(0, 32767);
        n0 = nout; feed(131071); wait_out(n0, got);
        chk("R7 positive saturation", last_out, 32767);
        n0 = nout; feed(-131072); wait_out(n0, got);
        chk("R7 negative saturation", last_out, -32768);
        write_coef(0, 1);
        cfg_shift = 5'd1;
        n0 = nout; feed(3); wait_out(n0, got);
        chk("R7 round half up positive", last_out, 2);
        n0 = nout; feed(-3); wait_out(n0, got);
        chk("R7 round half up negative", last_out, -1);

        // R9: unused coefficient addresses have no effect
        do_reset();
        cfg_taps = 6'd4; cfg_symmetric = 1'b0; cfg_decim = 8'd1; cfg_shift = 5'd0;
        load_coefs(21);
        write_coef(10, 32767);
        write_coef(31, -32768);
        for (int i = 0; i < 3; i++) begin
            n0 = nout;
            next_sample(s);
            feed(s);
            exp = model();
            wait_out(n0, got);
            chk("R9 unused coefficients ignored", last_out, exp);
        end

        // R8: back-to-back boundaries on a long filter
        do_reset();
        cfg_taps = 6'd63; cfg_symmetric = 1'b1; cfg_anti = 1'b0;
        cfg_decim = 8'd1; cfg_shift = 5'd6;
        load_coefs(30);
        n0 = nout;
        @(negedge clk);
        in_valid = 1'b1; in_data = 18'd1500; hist[hcnt] = 1500; hcnt++;
        exp = model();
        @(negedge clk);
        in_data = 18'h3F000; hist[hcnt] = -4096; hcnt++;
        @(negedge clk);
        in_data = 18'd900; hist[hcnt] = 900; hcnt++;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (80) @(negedge clk);
        chk("R8 overrun set", longint'(overrun), 1);
        chk("R8 only first boundary produced", longint'(nout - n0), 1);
        chk("R8 first result intact", last_out, exp);
        repeat (50) @(negedge clk);
        chk("R8 overrun sticky", longint'(overrun), 1);
        do_reset();
        @(negedge clk);
        chk("R1 overrun cleared by reset", longint'(overrun), 0);

        summary();
    end
endmodule